// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register that holds the outcomes of the most recently resolved branches. That register selects one of several tables of saturating counters. Low-order bits of the branch address then pick one counter inside the chosen table. As a result, a single branch address can train and read different counters depending on the path that led to it. No address tag is stored, so branches that share the same low address bits share counters.

Fetch presents a PC on the lookup side and receives a taken / not-taken guess in the same cycle, with no register on the path. When a branch resolves, its PC and real outcome arrive on the update side. The outcome moves the selected counter one step and is shifted into the history register at the next clock edge. Both the history depth and the counter width are parameters. The defaults give two history bits, 2-bit counters and 1024 counters in total. With zero history bits the block becomes a plain table of counters indexed by PC only.

Top module: `corr_dir_pred`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value 2^(n-1)-1, the history register is all zeros, and the prediction is not-taken for every PC.
- R2: The prediction is the most significant bit of the counter at index {history, PC[PC_LSB +: ROW_BITS]}, with the history forming the upper index bits, and it is valid in the same cycle as the lookup PC.
- R3: An update with outcome taken adds one to the selected counter and an update with outcome not-taken subtracts one. A counter at 2^n-1 stays there on taken, and a counter at 0 stays there on not-taken.
- R4: Each update changes only the one counter selected by the current history and the update PC. Cycles without an update change no counter.
- R5: Each update shifts the history left by one and puts the outcome into bit 0 (taken = 1). The oldest bit drops out. Without an update the history holds.
- R6: With 2-bit counters, a strongly-taken counter keeps predicting taken after one not-taken outcome and predicts not-taken only after a second consecutive one (and likewise in the other direction).
- R7: When a lookup and an update occur in the same cycle, the lookup result uses the counter and history values from before the update.
- R8: With zero history bits, the counter used for a PC depends only on PC[PC_LSB +: ROW_BITS], whatever outcomes came before.
- R9: No tag is kept: PCs that differ only outside PC[PC_LSB +: ROW_BITS] read and train the same counter.
- R10: The default configuration has 2 history bits, 2-bit counters and 1024 counters. That gives 4 tables of 256 rows, with the row taken from PC bits [9:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lookupPc | input | PC_W | Fetch PC to predict |
| predTaken | output | 1 | Combinational guess for lookupPc, 1 = taken |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | PC of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |

## Verification
Hand-built sequences drive one PC through saturation at both ends and through single and double reversals. These show the difference between a counter that moves once per update with hysteresis and one that wraps or flips at once. A short path-dependent sequence trains the same PC under different histories and then returns the history to zero. This shows whether the history selects the table and whether it shifts in the right order. PCs that differ only in high or byte-offset bits are looked up to show tagless aliasing, and a lookup taken in the same cycle as an update of the same PC shows pre-update reading. A long pseudo-random mix of updates and lookups over a small set of aliasing PCs, followed by a sweep of all rows, is compared against an arithmetic model. This mix finds stray writes to the wrong counter in both the correlating and the zero-history configurations.

// File: rtl/corr_pred_pkg.sv
package corr_pred_pkg;

  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic ctrUp;      // increment the selected counter
    logic ctrDown;    // decrement the selected counter
    logic histShift;  // shift the global history
    logic histBit;    // bit shifted into history position 0
  } predStrobe_t;

endpackage

// File: rtl/corr_pred_ctrl.sv
module corr_pred_ctrl
  import corr_pred_pkg::*;
#(
  parameter int CTR_BITS = 2
) (
  input  logic                updValid,
  input  logic                updTaken,
  input  logic [CTR_BITS-1:0] updCtr,
  input  logic                lookupMsb,
  output predStrobe_t         strobes,
  output logic                predTaken
);

  localparam logic [CTR_BITS-1:0] CTR_MAX = {CTR_BITS{1'b1}};
  localparam logic [CTR_BITS-1:0] CTR_MIN = '0;

  logic atMax;
  logic atMin;

  assign atMax = (updCtr == CTR_MAX);
  assign atMin = (updCtr == CTR_MIN);

  always_comb begin
    strobes           = '0;
    strobes.ctrUp     = updValid & updTaken & ~atMax;
    strobes.ctrDown   = updValid & ~updTaken & ~atMin;
    strobes.histShift = updValid;
    strobes.histBit   = updTaken;
  end

  assign predTaken = lookupMsb;

endmodule

// File: rtl/corr_pred_datapath.sv
module corr_pred_datapath
  import corr_pred_pkg::*;
#(
  parameter int HIST_BITS = 2,
  parameter int HIST_W    = 2,
  parameter int ROW_BITS  = 8,
  parameter int CTR_BITS  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ROW_BITS-1:0] lookupRow,
  input  logic [ROW_BITS-1:0] updRow,
  input  predStrobe_t         strobes,
  output logic                lookupMsb,
  output logic [CTR_BITS-1:0] updCtr,
  output logic [CTR_BITS-1:0] ctrNext,
  output logic [HIST_W-1:0]   histQ
);

  localparam int IDX_BITS = HIST_BITS + ROW_BITS;
  localparam int ENTRIES  = 1 << IDX_BITS;
  localparam logic [CTR_BITS-1:0] CTR_INIT = CTR_BITS'((1 << (CTR_BITS - 1)) - 1);

  logic [CTR_BITS-1:0] ctrMem [ENTRIES];
  logic [IDX_BITS-1:0] lookupIdx;
  logic [IDX_BITS-1:0] updIdx;

  generate
    if (HIST_BITS == 0) begin : g_flat
      logic unusedHist;
      assign unusedHist = strobes.histShift ^ strobes.histBit;
      assign histQ      = '0;
      assign lookupIdx  = lookupRow;
      assign updIdx     = updRow;
    end else begin : g_corr
      logic [HIST_BITS-1:0] histReg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          histReg <= '0;
        end else if (strobes.histShift) begin
          histReg <= HIST_BITS'({histReg, strobes.histBit});
        end
      end
      assign histQ     = histReg;
      assign lookupIdx = {histReg, lookupRow};
      assign updIdx    = {histReg, updRow};
    end
  endgenerate

  assign lookupMsb = ctrMem[lookupIdx][CTR_BITS-1];
  assign updCtr    = ctrMem[updIdx];

  always_comb begin
    if (strobes.ctrUp) begin
      ctrNext = updCtr + 1'b1;
    end else if (strobes.ctrDown) begin
      ctrNext = updCtr - 1'b1;
    end else begin
      ctrNext = updCtr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ctrMem[i] <= CTR_INIT;
      end
    end else if (strobes.ctrUp || strobes.ctrDown) begin
      ctrMem[updIdx] <= ctrNext;
    end
  end

endmodule

// File: rtl/corr_dir_pred.sv
module corr_dir_pred
  import corr_pred_pkg::*;
#(
  parameter int PC_W          = 32,
  parameter int PC_LSB        = 2,
  parameter int HIST_BITS     = 2,
  parameter int CTR_BITS      = 2,
  parameter int TOTAL_ENTRIES = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  localparam int TABLES   = 1 << HIST_BITS;
  localparam int ROWS     = TOTAL_ENTRIES / TABLES;
  localparam int ROW_BITS = $clog2(ROWS);
  localparam int HIST_W   = (HIST_BITS > 0) ? HIST_BITS : 1;

  predStrobe_t         strobes;
  logic                lookupMsb;
  logic [CTR_BITS-1:0] updCtr;
  logic [CTR_BITS-1:0] ctrNext;
  logic [HIST_W-1:0]   histQ;
  logic [ROW_BITS-1:0] lookupRow;
  logic [ROW_BITS-1:0] updRow;
  logic                unusedPcBits;

  assign lookupRow    = lookupPc[PC_LSB +: ROW_BITS];
  assign updRow       = updPc[PC_LSB +: ROW_BITS];
  assign unusedPcBits = ^{lookupPc, updPc};

  corr_pred_ctrl #(
    .CTR_BITS(CTR_BITS)
  ) u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .updCtr   (updCtr),
    .lookupMsb(lookupMsb),
    .strobes  (strobes),
    .predTaken(predTaken)
  );

  corr_pred_datapath #(
    .HIST_BITS(HIST_BITS),
    .HIST_W   (HIST_W),
    .ROW_BITS (ROW_BITS),
    .CTR_BITS (CTR_BITS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .lookupRow(lookupRow),
    .updRow   (updRow),
    .strobes  (strobes),
    .lookupMsb(lookupMsb),
    .updCtr   (updCtr),
    .ctrNext  (ctrNext),
    .histQ    (histQ)
  );

endmodule

// File: rtl/corr_pred_checker.sv
module corr_pred_checker
  import corr_pred_pkg::*;
#(
  parameter int HIST_BITS = 2,
  parameter int HIST_W    = 2,
  parameter int CTR_BITS  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                predTaken,
  input logic                updValid,
  input logic                updTaken,
  input logic [HIST_W-1:0]   histQ,
  input logic [CTR_BITS-1:0] updCtr,
  input logic [CTR_BITS-1:0] ctrNext,
  input predStrobe_t         strobes
);

  localparam logic [CTR_BITS-1:0] CTR_MAX = {CTR_BITS{1'b1}};

  AST_RESET_WEAK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) == 1'b0) |-> !predTaken); // R1

  AST_TAKEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && updTaken) |->
      (ctrNext == ((updCtr == CTR_MAX) ? CTR_MAX : CTR_BITS'(updCtr + 1'b1)))); // R3

  AST_NOT_TAKEN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && !updTaken) |->
      (ctrNext == ((updCtr == '0) ? '0 : CTR_BITS'(updCtr - 1'b1)))); // R3

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.ctrUp, strobes.ctrDown})); // R3

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !updValid |-> (!strobes.ctrUp && !strobes.ctrDown)); // R4

  generate
    if (CTR_BITS >= 2) begin : g_hyst
      AST_STRONG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (updValid && updCtr == CTR_MAX) |-> ctrNext[CTR_BITS-1]); // R6
    end
    if (HIST_BITS > 0) begin : g_hist
      AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        updValid |=> (histQ == HIST_W'({$past(histQ), $past(updTaken)}))); // R5
      AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !updValid |=> $stable(histQ)); // R5
    end
  endgenerate

endmodule

bind corr_dir_pred corr_pred_checker #(
  .HIST_BITS(HIST_BITS),
  .HIST_W   (HIST_W),
  .CTR_BITS (CTR_BITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .predTaken(predTaken),
  .updValid (updValid),
  .updTaken (updTaken),
  .histQ    (histQ),
  .updCtr   (updCtr),
  .ctrNext  (ctrNext),
  .strobes  (strobes)
);

// File: tb/corr_dir_pred_bench.sv
`timescale 1ns/1ps
module corr_dir_pred_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lookupPc = '0;
  logic [31:0] updPc = '0;
  logic        updValid = 1'b0;
  logic        updTaken = 1'b0;
  logic        predDef;
  logic        predFlat;

  int checks = 0;
  int failures = 0;
  int mDef[1024];
  int hDef;
  int mFlat[16];

  always #4 clk = ~clk;

  corr_dir_pred u_corr_dir_pred (
    .clk(clk), .rst_n(rst_n), .lookupPc(lookupPc), .predTaken(predDef),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  corr_dir_pred #(.HIST_BITS(0), .TOTAL_ENTRIES(16)) u_corr_dir_pred_flat (
    .clk(clk), .rst_n(rst_n), .lookupPc(lookupPc), .predTaken(predFlat),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int defIdx(input logic [31:0] pc);
    return (hDef << 8) | int'((pc >> 2) & 32'hFF);
  endfunction

  function automatic int flatIdx(input logic [31:0] pc);
    return int'((pc >> 2) & 32'hF);
  endfunction

  task automatic modelUpdate(input logic [31:0] pc, input bit t);
    int di;
    int fi;
    di = defIdx(pc);
    fi = flatIdx(pc);
    if (t) begin
      if (mDef[di] < 3) mDef[di]++;
      if (mFlat[fi] < 3) mFlat[fi]++;
    end else begin
      if (mDef[di] > 0) mDef[di]--;
      if (mFlat[fi] > 0) mFlat[fi]--;
    end
    hDef = ((hDef << 1) | int'(t)) & 3;
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    updValid = 1'b0;
    for (int i = 0; i < 1024; i++) mDef[i] = 1;
    for (int i = 0; i < 16; i++) mFlat[i] = 1;
    hDef = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // expDef / expFlat: literal expectations, -1 when none
  task automatic step(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                      input bit ut, input int expDef, input int expFlat, input string tag);
    @(negedge clk);
    lookupPc = lpc;
    updPc    = upc;
    updValid = uv;
    updTaken = ut;
    #1;
    check(int'(predDef), (mDef[defIdx(lpc)] >> 1) & 1, {tag, " model default"});
    check(int'(predFlat), (mFlat[flatIdx(lpc)] >> 1) & 1, {tag, " model flat"});
    if (expDef >= 0) check(int'(predDef), expDef, {tag, " default"});
    if (expFlat >= 0) check(int'(predFlat), expFlat, {tag, " flat"});
    @(posedge clk);
    if (uv) modelUpdate(upc, ut);
    #1 updValid = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] upc;
    logic [31:0] lpc;
    bit ut;
    bit uv;

    // R1: reset state, every row not-taken
    doReset();
    for (int i = 0; i < 256; i++) step(32'(i * 4), 0, 0, 0, 0, 0, "R1");

    // R2 R5 R7 R10: path-dependent training of one PC in the default config
    doReset();
    step(32'h100, 1, 32'h100, 1, 0, -1, "R7");   // pre-update read, then {00,64}->2
    step(32'h100, 0, 0, 0, 0, -1, "R2");         // history 01 selects a fresh counter
    step(32'h100, 1, 32'h100, 1, 0, -1, "R2");   // {01,64}->2, history 11
    step(32'h8, 1, 32'h8, 0, 0, -1, "R5");       // {11,2}->0, history 10
    step(32'hC, 1, 32'hC, 0, 0, -1, "R5");       // {10,3}->0, history 00
    step(32'h100, 0, 0, 0, 1, -1, "R5");         // history back to 00
    step(32'h500, 0, 0, 0, 1, -1, "R10");        // bit 10 outside row bits
    step(32'h300, 0, 0, 0, 0, -1, "R10");        // bit 9 inside row bits
    step(32'hFFFF_F103, 0, 0, 0, 1, -1, "R9");

    // R3 R6 R7 R8 R9: single counter walk in the zero-history config
    doReset();
    step(32'h20, 1, 32'h20, 1, -1, 0, "R3");
    step(32'h20, 1, 32'h20, 1, -1, 1, "R3");
    step(32'h20, 1, 32'h20, 1, -1, 1, "R3");     // saturates at 3
    step(32'h20, 1, 32'h20, 0, -1, 1, "R7");     // 3 -> 2, read before update
    step(32'h20, 0, 0, 0, -1, 1, "R6");          // one miss keeps taken
    step(32'h20, 1, 32'h20, 0, -1, 1, "R6");     // 2 -> 1
    step(32'h20, 0, 0, 0, -1, 0, "R6");          // second miss flips
    step(32'h20, 1, 32'h20, 0, -1, 0, "R3");     // 1 -> 0
    step(32'h20, 1, 32'h20, 0, -1, 0, "R3");     // stays 0
    step(32'h20, 1, 32'h20, 1, -1, 0, "R3");     // 0 -> 1
    step(32'h20, 0, 0, 0, -1, 0, "R3");          // no wrap from 0
    step(32'h20, 1, 32'h20, 1, -1, 0, "R6");     // 1 -> 2
    step(32'h20, 0, 0, 0, -1, 1, "R6");
    step(32'hF000_0023, 0, 0, 0, -1, 1, "R9");
    step(32'h24, 0, 0, 0, -1, 0, "R8");
    step(32'h60, 0, 0, 0, -1, 1, "R8");          // aliases row 8 of 16

    // R4 R5 R8: long pseudo-random mix over aliasing PCs
    doReset();
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0);
      upc = 32'({lfsr[2:0], 2'b00}) | (lfsr[3] ? 32'h400 : 32'h0) | (lfsr[4] ? 32'h40 : 32'h0);
      ut  = upc[2] ? hDef[0] : (lfsr[7] | lfsr[8]);
      uv  = lfsr[9] | lfsr[10] | lfsr[11];
      lpc = (k % 3 == 0) ? upc : 32'({lfsr[13:12], lfsr[6:5], lfsr[1], 2'b00});
      step(lpc, uv, upc, ut, -1, -1, "R4");
    end
    for (int i = 0; i < 256; i++) step(32'(i * 4), 0, 0, 0, -1, -1, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule